// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Unit

This block feeds an execution stage with whole instructions. Every instruction is one, two or three 16-bit words long. The unit reads the first word of an instruction and works out from its top two bits how many operand words follow. It then reads those words from the next even addresses and hands over the opcode word, the operand words, the length and the start address together, using a valid/ready handshake.

The memory port is either 8 or 16 bits wide, which is a build-time parameter. On a narrow port each word takes two bus accesses. Each access is stretched by a fixed number of wait states. An access that is not granted, because the execution side holds the bus, is retried in the next cycle. A one-instruction holding register lets the unit fetch one instruction beyond the one waiting at the output. When the execution stage takes a jump, a redirect pulse restarts fetching at the new address. An odd target stops fetching and raises an alignment error.

Top module: `ifetch_unit`

## Requirements
- R1: Length is decoded from bits [15:14] of the first word: 00 gives 1 word, 01 gives 2 words, 10 or 11 gives 3 words. `instr_len` reports this length as 1, 2 or 3.
- R2: Instructions are delivered in program order. Each is read from consecutive even addresses starting at `instr_addr`, and the next instruction starts at `instr_addr + 2*len`.
- R3: With an 8-bit port each word is built from two accesses, and the byte at the even address goes to bits [15:8]. With a 16-bit port one access returns the word, and `bus_rdata[15:8]` holds the byte at the even address.
- R4: Each access lasts 1+WAIT_STATES cycles. `bus_addr` is held for the whole access, and the read data is taken in its last cycle. With the grant always high, an L-word instruction becomes valid L×accesses-per-word×(1+WAIT_STATES) cycles after the redirect edge.
- R5: A request seen with `bus_gnt` low is repeated in the next cycle at the same address. Each denied cycle delays delivery by one cycle.
- R6: A redirect to an even address discards any partly read instruction and any instruction held in the unit. `instr_valid` is low in the next cycle, and fetching restarts at the target. A handshake in the redirect cycle does not count as a delivery.
- R7: A redirect to an odd address sets `align_err` from the next cycle. While `align_err` is set there are no bus requests and no valid instructions. The next redirect to an even address clears `align_err`.
- R8: While `instr_valid` is high and `instr_ready` is low, all instruction outputs hold their values until accepted or redirected.
- R9: While the output is stalled, one more instruction is fetched into the holding register. After that `bus_req` stays low until space frees up.
- R10: Operand word outputs beyond the instruction length read zero.
- R11: After reset `instr_valid` and `align_err` are low, and fetching begins at BOOT_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | output | 1 | Memory access request |
| bus_addr | output | ADDR_W | Byte address of the access |
| bus_gnt | input | 1 | Grant; low means the access is retried |
| bus_rdata | input | BUS_W | Read data, taken in the last cycle of an access |
| redir_valid | input | 1 | Redirect pulse |
| redir_addr | input | ADDR_W | Redirect target address |
| align_err | output | 1 | Odd redirect target; fetching stopped |
| instr_valid | output | 1 | Instruction available |
| instr_ready | input | 1 | Execution stage accepts the instruction |
| instr_addr | output | ADDR_W | Address of the first word |
| instr_len | output | 2 | Length in words (1 to 3) |
| instr_w0 | output | 16 | Opcode word |
| instr_w1 | output | 16 | Second word or zero |
| instr_w2 | output | 16 | Third word or zero |

## Verification
The bench builds two copies of the unit side by side. One has an 8-bit port with two wait states and the other a 16-bit port with none, and both receive the same grant, ready and redirect stimulus. The narrow copy exercises the high-byte register, the wait counter and retries that arrive mid-word. The wide copy exercises back-to-back single-cycle words, where a push and the next request share an edge. Exact latency checks for both copies are derived from accesses per word and wait states.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  typedef logic [15:0] word_t;

  typedef struct packed {
    logic [1:0] len;
    word_t      w0;
    word_t      w1;
    word_t      w2;
  } instr_t;

  // Instruction length in words from the opcode word
  function automatic logic [1:0] ifu_len_of(input word_t w);
    logic [1:0] n;
    case (w[15:14])
      2'b00:   n = 2'd1;
      2'b01:   n = 2'd2;
      default: n = 2'd3;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/ifu_word_reader.sv
module ifu_word_reader #(
  parameter int ADDR_W      = 24,
  parameter int BUS_W       = 16,
  parameter int WAIT_STATES = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              word_req,
  input  logic [ADDR_W-1:0] word_addr,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic [BUS_W-1:0]  bus_rdata,
  output logic              word_done,
  output logic [15:0]       word_data
);
  localparam int CNT_W = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;

  logic waiting_q;
  logic granted;
  logic beat_fire;
  logic last_beat;

  assign bus_req   = word_req && !waiting_q;
  assign granted   = bus_req && bus_gnt;
  assign word_done = beat_fire && last_beat;

  // Access timing: grant cycle plus WAIT_STATES further cycles
  generate
    if (WAIT_STATES > 0) begin : g_wait
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             wait_d, cnt_en;

      always_comb begin
        wait_d = waiting_q;
        cnt_d  = cnt_q;
        cnt_en = 1'b0;
        if (flush) begin
          wait_d = 1'b0;
        end else if (granted) begin
          wait_d = 1'b1;
          cnt_d  = CNT_W'(WAIT_STATES);
          cnt_en = 1'b1;
        end else if (waiting_q) begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
          if (cnt_q == CNT_W'(1)) wait_d = 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          waiting_q <= 1'b0;
          cnt_q     <= '0;
        end else begin
          waiting_q <= wait_d;
          if (cnt_en) cnt_q <= cnt_d;
        end
      end

      assign beat_fire = waiting_q && (cnt_q == CNT_W'(1));
    end else begin : g_nowait
      assign waiting_q = 1'b0;
      assign beat_fire = granted;
    end
  endgenerate

  // Word assembly from one or two accesses
  generate
    if (BUS_W == 8) begin : g_narrow
      logic       beat_q, beat_d, beat_en;
      logic [7:0] hi_q;
      logic       hi_en;

      always_comb begin
        beat_en = flush || beat_fire;
        beat_d  = flush ? 1'b0 : !beat_q;
        hi_en   = beat_fire && !beat_q && !flush;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          beat_q <= 1'b0;
          hi_q   <= '0;
        end else begin
          if (beat_en) beat_q <= beat_d;
          if (hi_en)   hi_q   <= bus_rdata;
        end
      end

      assign bus_addr  = {word_addr[ADDR_W-1:1], word_addr[0] | beat_q};
      assign last_beat = beat_q;
      assign word_data = {hi_q, bus_rdata};
    end else begin : g_wide
      assign bus_addr  = word_addr;
      assign last_beat = 1'b1;
      assign word_data = bus_rdata;
    end
  endgenerate
endmodule

// File: rtl/ifu_ctrl.sv
module ifu_ctrl
  import ifu_pkg::*;
#(
  parameter int                ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_addr,
  input  logic              hold_full,
  output logic              word_req,
  output logic [ADDR_W-1:0] word_addr,
  input  logic              word_done,
  input  word_t             word_data,
  output logic              push,
  output instr_t            push_instr,
  output logic [ADDR_W-1:0] push_addr,
  output logic              align_err
);
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [1:0]        widx_q, widx_d, len_q, len_d;
  word_t             w0_q, w1_q, w0_d, w1_d;
  logic              run_q, run_d, err_q, err_d;
  logic              pc_en, idx_en;
  logic [1:0]        cur_len;
  logic              last_word;

  assign word_req  = run_q && !((widx_q == 2'd0) && hold_full);
  assign word_addr = pc_q + ADDR_W'({widx_q, 1'b0});
  assign cur_len   = (widx_q == 2'd0) ? ifu_len_of(word_data) : len_q;
  assign last_word = word_done && (widx_q == cur_len - 2'd1);
  assign push      = last_word && !redir_valid;
  assign push_addr = pc_q;
  assign align_err = err_q;

  always_comb begin
    push_instr.len = cur_len;
    push_instr.w0  = (widx_q == 2'd0) ? word_data : w0_q;
    push_instr.w1  = (widx_q == 2'd1) ? word_data :
                     (widx_q == 2'd2) ? w1_q : '0;
    push_instr.w2  = (widx_q == 2'd2) ? word_data : '0;
  end

  always_comb begin
    pc_d   = pc_q;
    widx_d = widx_q;
    len_d  = len_q;
    w0_d   = w0_q;
    w1_d   = w1_q;
    run_d  = run_q;
    err_d  = err_q;
    pc_en  = 1'b0;
    idx_en = 1'b0;
    if (redir_valid) begin
      pc_d   = redir_addr;
      widx_d = 2'd0;
      run_d  = !redir_addr[0];
      err_d  = redir_addr[0];
      pc_en  = 1'b1;
      idx_en = 1'b1;
    end else if (word_done) begin
      idx_en = 1'b1;
      if (last_word) begin
        pc_d   = pc_q + ADDR_W'({cur_len, 1'b0});
        pc_en  = 1'b1;
        widx_d = 2'd0;
      end else begin
        widx_d = widx_q + 2'd1;
        if (widx_q == 2'd0) begin
          len_d = cur_len;
          w0_d  = word_data;
        end
        if (widx_q == 2'd1) w1_d = word_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= BOOT_ADDR;
      widx_q <= 2'd0;
      len_q  <= 2'd1;
      w0_q   <= '0;
      w1_q   <= '0;
      run_q  <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      if (pc_en) pc_q <= pc_d;
      if (idx_en) begin
        widx_q <= widx_d;
        len_q  <= len_d;
        w0_q   <= w0_d;
        w1_q   <= w1_d;
      end
      run_q <= run_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/ifu_outbuf.sv
module ifu_outbuf #(
  parameter int DW = 74
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  output logic          hold_valid
);
  logic [DW-1:0] hold_q, out_d, hold_d;
  logic          ov_d, hv_d, out_en, hold_en, advance;

  assign advance = !out_valid || out_ready;

  always_comb begin
    ov_d    = out_valid;
    hv_d    = hold_valid;
    out_d   = out_data;
    hold_d  = hold_q;
    out_en  = 1'b0;
    hold_en = 1'b0;
    if (flush) begin
      ov_d = 1'b0;
      hv_d = 1'b0;
    end else if (advance) begin
      if (hold_valid) begin
        out_d   = hold_q;
        out_en  = 1'b1;
        ov_d    = 1'b1;
        hv_d    = push;
        hold_d  = push_data;
        hold_en = push;
      end else begin
        ov_d   = push;
        out_d  = push_data;
        out_en = push;
      end
    end else if (push) begin
      hv_d    = 1'b1;
      hold_d  = push_data;
      hold_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      hold_valid <= 1'b0;
      out_data   <= '0;
      hold_q     <= '0;
    end else begin
      out_valid  <= ov_d;
      hold_valid <= hv_d;
      if (out_en)  out_data <= out_d;
      if (hold_en) hold_q   <= hold_d;
    end
  end
endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
  import ifu_pkg::*;
#(
  parameter int                ADDR_W      = 24,
  parameter int                BUS_W       = 16,
  parameter int                WAIT_STATES = 0,
  parameter logic [ADDR_W-1:0] BOOT_ADDR   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic [BUS_W-1:0]  bus_rdata,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_addr,
  output logic              align_err,
  output logic              instr_valid,
  input  logic              instr_ready,
  output logic [ADDR_W-1:0] instr_addr,
  output logic [1:0]        instr_len,
  output logic [15:0]       instr_w0,
  output logic [15:0]       instr_w1,
  output logic [15:0]       instr_w2
);
  localparam int IW = $bits(instr_t);
  localparam int DW = ADDR_W + IW;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic              word_req, word_done, push, hold_full;
  logic [ADDR_W-1:0] word_addr, push_addr;
  word_t             word_data;
  instr_t            push_instr, out_instr;
  logic [DW-1:0]     out_data;

  ifu_word_reader #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .WAIT_STATES(WAIT_STATES)) u_reader (
    .clk(clk), .rst_n(rst_q_n), .flush(redir_valid),
    .word_req(word_req), .word_addr(word_addr),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .word_done(word_done), .word_data(word_data)
  );

  ifu_ctrl #(.ADDR_W(ADDR_W), .BOOT_ADDR(BOOT_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_q_n),
    .redir_valid(redir_valid), .redir_addr(redir_addr), .hold_full(hold_full),
    .word_req(word_req), .word_addr(word_addr),
    .word_done(word_done), .word_data(word_data),
    .push(push), .push_instr(push_instr), .push_addr(push_addr),
    .align_err(align_err)
  );

  ifu_outbuf #(.DW(DW)) u_outbuf (
    .clk(clk), .rst_n(rst_q_n), .flush(redir_valid),
    .push(push), .push_data({push_addr, push_instr}),
    .out_valid(instr_valid), .out_data(out_data), .out_ready(instr_ready),
    .hold_valid(hold_full)
  );

  assign instr_addr = out_data[DW-1:IW];
  assign out_instr  = out_data[IW-1:0];
  assign instr_len  = out_instr.len;
  assign instr_w0   = out_instr.w0;
  assign instr_w1   = out_instr.w1;
  assign instr_w2   = out_instr.w2;
endmodule

// File: rtl/ifu_checker.sv
module ifu_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              redir_valid,
  input logic [ADDR_W-1:0] redir_addr,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              align_err,
  input logic              instr_valid,
  input logic              instr_ready,
  input logic [ADDR_W-1:0] instr_addr,
  input logic [1:0]        instr_len,
  input logic [15:0]       instr_w0,
  input logic [15:0]       instr_w1,
  input logic [15:0]       instr_w2
);
  p_len_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> instr_len == (instr_w0[15] ? 2'd3 : (instr_w0[14] ? 2'd2 : 2'd1)));

  p_even_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> !instr_addr[0]);

  p_retry_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt && !redir_valid |=> bus_req && $stable(bus_addr));

  p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !instr_valid);

  p_odd_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid && redir_addr[0] |=> align_err);

  p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !bus_req && !instr_valid);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && !instr_ready && !redir_valid |=>
      instr_valid && $stable(instr_addr) && $stable(instr_len) &&
      $stable(instr_w0) && $stable(instr_w1) && $stable(instr_w2));

  p_spare_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && instr_len != 2'd3 |-> instr_w2 == 16'h0 &&
      (instr_len != 2'd1 || instr_w1 == 16'h0));
endmodule

bind ifetch_unit ifu_checker #(.ADDR_W(ADDR_W)) u_ifu_checker (
  .clk(clk), .rst_n(rst_q_n),
  .redir_valid(redir_valid), .redir_addr(redir_addr),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
  .align_err(align_err), .instr_valid(instr_valid), .instr_ready(instr_ready),
  .instr_addr(instr_addr), .instr_len(instr_len),
  .instr_w0(instr_w0), .instr_w1(instr_w1), .instr_w2(instr_w2)
);

// File: tb/ifetch_unit_bench.sv
`timescale 1ns/1ps
module ifetch_unit_bench;
  localparam logic [15:0] BOOT = 16'h0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gnt = 1'b0;
  logic        rdy = 1'b0;
  logic        redir = 1'b0;
  logic [15:0] raddr = 16'h0;

  always #2.5 clk = ~clk;

  int nvec = 0;
  int nfail = 0;

  logic [1:0]  l_valid, l_req, l_err;
  logic [15:0] l_addr [2];
  logic [15:0] l_w0 [2];
  logic [15:0] l_w1 [2];
  logic [15:0] l_w2 [2];
  logic [1:0]  l_len [2];

  function automatic logic [7:0] mb(input logic [15:0] a);
    logic [7:0] p;
    p = a[7:0] * 8'd167;
    return (p + a[10:3]) ^ 8'h5A;
  endfunction

  function automatic logic [15:0] memw(input logic [15:0] a);
    return {mb({a[15:1], 1'b0}), mb({a[15:1], 1'b1})};
  endfunction

  function automatic logic [1:0] exp_len(input logic [15:0] w);
    return (w[15:14] == 2'b00) ? 2'd1 : ((w[15:14] == 2'b01) ? 2'd2 : 2'd3);
  endfunction

  function automatic int lane_beats(input int l);
    return (l == 0) ? 2 : 1;
  endfunction

  function automatic int lane_ws(input int l);
    return (l == 0) ? 2 : 0;
  endfunction

  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int BW = (g == 0) ? 8 : 16;
    localparam int WS = (g == 0) ? 2 : 0;
    logic [BW-1:0] rdata;
    logic [15:0]   baddr;
    logic          req, err, vld;
    logic [15:0]   ia, w0, w1, w2;
    logic [1:0]    ln;

    assign rdata = (BW == 8) ? BW'(mb(baddr)) : BW'(memw(baddr));

    ifetch_unit #(.ADDR_W(16), .BUS_W(BW), .WAIT_STATES(WS), .BOOT_ADDR(BOOT)) u_ifetch_unit (
      .clk(clk), .rst_n(rst_n),
      .bus_req(req), .bus_addr(baddr), .bus_gnt(gnt), .bus_rdata(rdata),
      .redir_valid(redir), .redir_addr(raddr), .align_err(err),
      .instr_valid(vld), .instr_ready(rdy), .instr_addr(ia), .instr_len(ln),
      .instr_w0(w0), .instr_w1(w1), .instr_w2(w2)
    );

    assign l_valid[g] = vld;
    assign l_req[g]   = req;
    assign l_err[g]   = err;
    assign l_addr[g]  = ia;
    assign l_len[g]   = ln;
    assign l_w0[g]    = w0;
    assign l_w1[g]    = w1;
    assign l_w2[g]    = w2;
  end

  logic [15:0] exp_pc [2];
  logic [15:0] s_addr [2];
  logic [15:0] s_w0 [2];
  bit   [1:0]  stall, halted, clr_pend;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive inputs at the falling edge, then score the outputs
  task automatic cycle(input bit g, input bit r, input bit rv, input logic [15:0] ra);
    @(negedge clk);
    gnt = g; rdy = r; redir = rv; raddr = ra;
    for (int l = 0; l < 2; l++) begin
      if (clr_pend[l]) begin
        chk(!l_err[l], "R7 cleared", 64'(l_err[l]), 64'd0);
        clr_pend[l] = 1'b0;
      end
      if (stall[l] && !rv)
        chk(l_valid[l] && l_addr[l] == s_addr[l] && l_w0[l] == s_w0[l], "R8 stable",
            {l_valid[l], l_addr[l], l_w0[l]}, {1'b1, s_addr[l], s_w0[l]});
      if (halted[l] && !rv)
        chk(l_err[l] && !l_req[l] && !l_valid[l], "R7 halted",
            {l_err[l], l_req[l], l_valid[l]}, 3'b100);
      if (!rv && l_valid[l] && r && !halted[l]) begin
        logic [15:0] e0, e1, e2;
        logic [1:0]  el;
        e0 = memw(exp_pc[l]);
        el = exp_len(e0);
        e1 = (el >= 2'd2) ? memw(exp_pc[l] + 16'd2) : 16'h0;
        e2 = (el == 2'd3) ? memw(exp_pc[l] + 16'd4) : 16'h0;
        chk(l_addr[l] == exp_pc[l], "R2 addr", l_addr[l], exp_pc[l]);
        chk(l_len[l] == el, "R1 len", l_len[l], el);
        chk(l_w0[l] == e0, "R3 w0", l_w0[l], e0);
        chk(l_w1[l] == e1, (el >= 2'd2) ? "R3 w1" : "R10 w1", l_w1[l], e1);
        chk(l_w2[l] == e2, (el == 2'd3) ? "R3 w2" : "R10 w2", l_w2[l], e2);
        exp_pc[l] = exp_pc[l] + {13'd0, el, 1'b0};
      end
      stall[l]  = !rv && l_valid[l] && !r;
      s_addr[l] = l_addr[l];
      s_w0[l]   = l_w0[l];
      if (rv) begin
        if (ra[0]) halted[l] = 1'b1;
        else begin
          halted[l]   = 1'b0;
          clr_pend[l] = 1'b1;
          exp_pc[l]   = ra;
        end
      end
    end
  endtask

  task automatic latency(input logic [15:0] t, input int deny, input string tag);
    int first [2];
    first[0] = 0; first[1] = 0;
    cycle(1'b1, 1'b1, 1'b1, t);
    for (int k = 1; k <= 80; k++) begin
      cycle(k > deny, 1'b1, 1'b0, 16'h0);
      for (int l = 0; l < 2; l++)
        if (first[l] == 0 && l_valid[l]) first[l] = k;
    end
    for (int l = 0; l < 2; l++) begin
      int n;
      n = int'(exp_len(memw(t))) * lane_beats(l) * (1 + lane_ws(l)) + 1 + deny;
      chk(first[l] == n, tag, 64'(first[l]), 64'(n));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20611));
    stall = '0; halted = '0; clr_pend = '0;
    exp_pc[0] = BOOT; exp_pc[1] = BOOT;
    repeat (4) @(negedge clk);
    for (int l = 0; l < 2; l++)
      chk(!l_valid[l] && !l_err[l], "R11 reset", {l_valid[l], l_err[l]}, 2'b00);
    rst_n = 1'b1;

    // R11: first instruction comes from the boot address (held, not taken)
    for (int k = 0; k < 60; k++) cycle(1'b1, 1'b0, 1'b0, 16'h0);
    for (int l = 0; l < 2; l++)
      chk(l_valid[l] && l_addr[l] == BOOT, "R11 boot", {l_valid[l], l_addr[l]}, {1'b1, BOOT});
    for (int k = 0; k < 40; k++) cycle(1'b1, 1'b1, 1'b0, 16'h0);

    // R4 / R5: exact latency, with and without denied grants
    latency(16'h0040, 0, "R4 latency");
    latency(16'h0046, 0, "R4 latency");
    latency(16'h0040, 3, "R5 retry");

    // R9: output stalled, one more instruction buffered, then bus idle
    cycle(1'b1, 1'b0, 1'b1, 16'h0080);
    for (int k = 0; k < 80; k++) cycle(1'b1, 1'b0, 1'b0, 16'h0);
    for (int l = 0; l < 2; l++)
      chk(!l_req[l] && l_valid[l] && l_addr[l] == 16'h0080, "R9 holding",
          {l_req[l], l_valid[l], l_addr[l]}, {1'b0, 1'b1, 16'h0080});
    for (int k = 0; k < 40; k++) cycle(1'b1, 1'b1, 1'b0, 16'h0);

    // R7: odd target stops fetching, even target restarts it
    cycle(1'b1, 1'b1, 1'b1, 16'h0101);
    for (int k = 0; k < 20; k++) cycle(1'b1, 1'b1, 1'b0, 16'h0);
    cycle(1'b1, 1'b1, 1'b1, 16'h0200);
    for (int k = 0; k < 40; k++) cycle(1'b1, 1'b1, 1'b0, 16'h0);

    // R6 and mixed traffic: random grant, ready and redirects
    for (int k = 0; k < 6000; k++) begin
      bit g, r, rv;
      logic [15:0] ra;
      g  = ($urandom % 4) != 0;
      r  = ($urandom % 3) != 0;
      rv = ($urandom % 60) == 0;
      ra = {6'd0, 9'($urandom), ($urandom % 8) == 0};
      cycle(g, r, rv, ra);
    end
    cycle(1'b1, 1'b1, 1'b1, 16'h0010);
    for (int k = 0; k < 60; k++) cycle(1'b1, 1'b1, 1'b0, 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule